// File: doc/BRIEF.md
# Hardware Page Table Walker with Usage-Bit Update

This block services a translation miss for a 32-bit single-issue core without any help from software. When the TLB misses, the cache controller hands the walker the virtual address, a read/write flag, the cluster number of the requesting processor and the cluster number of the memory bank that the access targets. The walker reads one page table entry over a simple word-wide memory port and inspects it. If the entry is not valid, the walker reports a fault. Otherwise it reports the physical address and writes the TLB.

Each page table entry carries three usage bits that the walker maintains. The dirty bit is set when the access is a write. The walker then compares the two cluster numbers. If they are equal, it sets the same-cluster access bit. If they differ, it sets the cross-cluster access bit. When any of these bits changes, the walker writes the entry back to memory before it refills the TLB. When nothing changes, it skips the write.

Only one walk runs at a time. A busy output holds off further miss requests until the current walk finishes. The page table is single-level and uses 4 KiB pages.

Top module: `ptw_walker`

## Requirements
- R1: After reset, `busy`, `mem_req_valid`, `done_valid` and `refill_we` are all 0.
- R2: A miss accepted while idle issues a read (`mem_req_write`=0) at address `pt_base + vaddr[31:12]*4`.
- R3: `busy` is 1 from the cycle after a miss is accepted until the walk completes. A `miss_valid` presented while busy is ignored: it causes no memory read and no second completion.
- R4: An entry with bit 0 (valid) clear completes with `done_fault`=1. It causes no `refill_we` and no memory write.
- R5: On success, `done_paddr` = {entry bits [PA_W-9:4] as the page number, vaddr[11:0]}. `refill_we` pulses with `refill_vpn` = vaddr[31:12] and `refill_ppn` = that page number.
- R6: A write miss sets bit 1 (dirty) in the entry.
- R7: When the requester cluster equals the target cluster, bit 2 (same-cluster access) is set and bit 3 is left unchanged.
- R8: When the two cluster numbers differ, bit 3 (cross-cluster access) is set and bit 2 is left unchanged.
- R9: If no usage bit changes, no memory write is issued.
- R10: If a usage bit changes, one memory write of the updated entry to the same entry address precedes the refill.
- R11: A read miss leaves bit 1 (dirty) unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pt_base | input | PA_W | Page table base address |
| miss_valid | input | 1 | Miss request, taken when not busy |
| miss_vaddr | input | 32 | Missing virtual address |
| miss_write | input | 1 | 1 for a store access |
| miss_src_cluster | input | CL_W | Cluster of the requesting processor |
| miss_dst_cluster | input | CL_W | Cluster of the target memory bank |
| busy | output | 1 | Walk in progress |
| mem_req_valid | output | 1 | Memory request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 for an entry writeback |
| mem_req_addr | output | PA_W | Entry address |
| mem_req_wdata | output | 32 | Updated entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_rdata | input | 32 | Entry read from memory |
| done_valid | output | 1 | Walk completes this cycle |
| done_fault | output | 1 | Walk ended in a fault |
| done_paddr | output | PA_W | Translated physical address |
| refill_we | output | 1 | TLB write strobe |
| refill_vpn | output | 20 | Virtual page number to store |
| refill_ppn | output | PA_W-12 | Physical page number to store |

## Verification
Two functions can land in the same writeback: setting the dirty bit and setting one of the access bits. The bench provokes this with a write miss from one cluster to a bank in another cluster, on an entry whose usage bits are all clear. It then judges the single captured write word, which must carry both bit 1 and bit 3, with bit 2 still clear and the page number intact. A second overlap is a new miss arriving while a walk is running. The bench judges this case by counting memory reads and completions, and by checking which page reached the TLB.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int VA_W      = 32;
    localparam int PAGE_BITS = 12;
    localparam int VPN_W     = VA_W - PAGE_BITS;
    localparam int PTE_W     = 32;

    localparam int PTE_V       = 0;
    localparam int PTE_D       = 1;
    localparam int PTE_LOC     = 2;
    localparam int PTE_REM     = 3;
    localparam int PTE_PPN_LSB = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WAIT,
        ST_CHECK,
        ST_WB,
        ST_REFILL,
        ST_FAULT
    } walk_state_e;

    typedef struct packed {
        logic [VA_W-1:0] vaddr;
        logic            is_write;
        logic            same_cluster;
    } walk_req_t;

    function automatic logic [VPN_W-1:0] vpn_of(input logic [VA_W-1:0] va);
        return va[VA_W-1:PAGE_BITS];
    endfunction

    function automatic logic [PAGE_BITS-1:0] offset_of(input logic [VA_W-1:0] va);
        return va[PAGE_BITS-1:0];
    endfunction
endpackage

// File: rtl/ptw_pte_update.sv
module ptw_pte_update
    import ptw_pkg::*;
(
    input  logic [PTE_W-1:0] pte_in,
    input  logic             is_write,
    input  logic             same_cluster,
    output logic [PTE_W-1:0] pte_out,
    output logic             entry_valid,
    output logic             changed
);
    always_comb begin
        pte_out = pte_in;
        if (is_write) begin
            pte_out[PTE_D] = 1'b1;
        end
        if (same_cluster) begin
            pte_out[PTE_LOC] = 1'b1;
        end else begin
            pte_out[PTE_REM] = 1'b1;
        end
    end

    assign entry_valid = pte_in[PTE_V];
    assign changed     = (pte_out != pte_in);
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
    import ptw_pkg::*;
#(
    parameter int PA_W = 40,
    localparam int PPN_W = PA_W - PAGE_BITS
) (
    input  logic [PA_W-1:0]      pt_base,
    input  logic [VA_W-1:0]      vaddr,
    input  logic [PTE_W-1:0]     pte,
    output logic [PA_W-1:0]      pte_addr,
    output logic [PPN_W-1:0]     ppn,
    output logic [PA_W-1:0]      paddr
);
    localparam int IDX_W = VPN_W + 2;

    logic [IDX_W-1:0] byte_index;

    assign byte_index = {vpn_of(vaddr), 2'b00};
    assign pte_addr   = pt_base + {{(PA_W-IDX_W){1'b0}}, byte_index};
    assign ppn        = pte[PTE_PPN_LSB +: PPN_W];
    assign paddr      = {ppn, offset_of(vaddr)};
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int PA_W = 40,
    parameter int CL_W = 4,
    localparam int PPN_W = PA_W - PAGE_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PA_W-1:0]   pt_base,
    input  logic              miss_valid,
    input  logic [31:0]       miss_vaddr,
    input  logic              miss_write,
    input  logic [CL_W-1:0]   miss_src_cluster,
    input  logic [CL_W-1:0]   miss_dst_cluster,
    output logic              busy,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [PA_W-1:0]   mem_req_addr,
    output logic [31:0]       mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [31:0]       mem_rsp_rdata,
    output logic              done_valid,
    output logic              done_fault,
    output logic [PA_W-1:0]   done_paddr,
    output logic              refill_we,
    output logic [19:0]       refill_vpn,
    output logic [PPN_W-1:0]  refill_ppn
);
    walk_state_e      state_q, state_d;
    walk_req_t        req_q;
    logic [PTE_W-1:0] pte_q;
    logic [PTE_W-1:0] pte_upd;
    logic             pte_ok;
    logic             pte_chg;
    logic [PA_W-1:0]  pte_addr;
    logic [PPN_W-1:0] ppn;
    logic [PA_W-1:0]  paddr;

    ptw_pte_update upd_i (
        .pte_in       (pte_q),
        .is_write     (req_q.is_write),
        .same_cluster (req_q.same_cluster),
        .pte_out      (pte_upd),
        .entry_valid  (pte_ok),
        .changed      (pte_chg)
    );

    ptw_addr_gen #(.PA_W(PA_W)) addr_i (
        .pt_base  (pt_base),
        .vaddr    (req_q.vaddr),
        .pte      (pte_q),
        .pte_addr (pte_addr),
        .ppn      (ppn),
        .paddr    (paddr)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (miss_valid)    state_d = ST_FETCH;
            ST_FETCH:  if (mem_req_ready) state_d = ST_WAIT;
            ST_WAIT:   if (mem_rsp_valid) state_d = ST_CHECK;
            ST_CHECK: begin
                if (!pte_ok)      state_d = ST_FAULT;
                else if (pte_chg) state_d = ST_WB;
                else              state_d = ST_REFILL;
            end
            ST_WB:     if (mem_req_ready) state_d = ST_REFILL;
            ST_REFILL: state_d = ST_IDLE;
            ST_FAULT:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            req_q   <= '0;
            pte_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && miss_valid) begin
                req_q.vaddr        <= miss_vaddr;
                req_q.is_write     <= miss_write;
                req_q.same_cluster <= (miss_src_cluster == miss_dst_cluster);
            end
            if (state_q == ST_WAIT && mem_rsp_valid) begin
                pte_q <= mem_rsp_rdata;
            end else if (state_q == ST_CHECK && pte_ok) begin
                pte_q <= pte_upd;
            end
        end
    end

    assign busy          = (state_q != ST_IDLE);
    assign mem_req_valid = (state_q == ST_FETCH) || (state_q == ST_WB);
    assign mem_req_write = (state_q == ST_WB);
    assign mem_req_addr  = pte_addr;
    assign mem_req_wdata = pte_q;
    assign done_valid    = (state_q == ST_REFILL) || (state_q == ST_FAULT);
    assign done_fault    = (state_q == ST_FAULT);
    assign done_paddr    = paddr;
    assign refill_we     = (state_q == ST_REFILL);
    assign refill_vpn    = vpn_of(req_q.vaddr);
    assign refill_ppn    = ppn;
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
    parameter int PA_W = 40
) (
    input logic            clk,
    input logic            rst,
    input logic            busy,
    input logic            mem_req_valid,
    input logic            mem_req_ready,
    input logic            mem_req_write,
    input logic [31:0]     mem_req_wdata,
    input logic            done_valid,
    input logic            done_fault,
    input logic            refill_we
);
    // R3
    req_needs_busy_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> busy);

    // R3
    done_frees_chk: assert property (@(posedge clk) disable iff (rst)
        done_valid |=> !busy);

    // R4
    fault_no_refill_chk: assert property (@(posedge clk) disable iff (rst)
        !(refill_we && done_fault));

    // R4
    fault_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_write) |-> mem_req_wdata[0]);

    // R10
    wb_then_refill_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_write && mem_req_ready) |=> refill_we);
endmodule

bind ptw_walker ptw_walker_chk #(.PA_W(PA_W)) chk_i (
    .clk           (clk),
    .rst           (rst),
    .busy          (busy),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_wdata (mem_req_wdata),
    .done_valid    (done_valid),
    .done_fault    (done_fault),
    .refill_we     (refill_we)
);

// File: tb/ptw_walker_tb_top.sv
module ptw_walker_tb_top;
    localparam int PA_W  = 40;
    localparam int CL_W  = 4;
    localparam int PPN_W = PA_W - 12;
    localparam logic [PA_W-1:0] BASE = 40'h00_0000_1000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              miss_valid = 1'b0;
    logic [31:0]       miss_vaddr = '0;
    logic              miss_write = 1'b0;
    logic [CL_W-1:0]   miss_src_cluster = '0;
    logic [CL_W-1:0]   miss_dst_cluster = '0;
    logic              busy, mem_req_valid, mem_req_write;
    logic [PA_W-1:0]   mem_req_addr;
    logic [31:0]       mem_req_wdata;
    logic              mem_rsp_valid;
    logic [31:0]       mem_rsp_rdata;
    logic              done_valid, done_fault, refill_we;
    logic [PA_W-1:0]   done_paddr;
    logic [19:0]       refill_vpn;
    logic [PPN_W-1:0]  refill_ppn;

    always #2 clk = ~clk;

    ptw_walker #(.PA_W(PA_W), .CL_W(CL_W)) dut_i (
        .clk(clk), .rst(rst), .pt_base(BASE),
        .miss_valid(miss_valid), .miss_vaddr(miss_vaddr), .miss_write(miss_write),
        .miss_src_cluster(miss_src_cluster), .miss_dst_cluster(miss_dst_cluster),
        .busy(busy), .mem_req_valid(mem_req_valid), .mem_req_ready(1'b1),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_rdata(mem_rsp_rdata), .done_valid(done_valid),
        .done_fault(done_fault), .done_paddr(done_paddr), .refill_we(refill_we),
        .refill_vpn(refill_vpn), .refill_ppn(refill_ppn)
    );

    // memory model
    logic [31:0]     pmem [0:63];
    logic            pre_en = 1'b0;
    logic [5:0]      pre_idx = '0;
    logic [31:0]     pre_data = '0;
    int              rd_count, wr_count;
    logic [PA_W-1:0] last_rd_addr, last_wr_addr;
    logic [31:0]     last_wr_data;
    logic [PA_W-1:0] off;
    assign off = mem_req_addr - BASE;

    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (pre_en) pmem[pre_idx] <= pre_data;
        if (rst) begin
            rd_count <= 0;
            wr_count <= 0;
            last_rd_addr <= '0;
            last_wr_addr <= '0;
            last_wr_data <= '0;
        end else if (mem_req_valid) begin
            if (mem_req_write) begin
                pmem[off[7:2]] <= mem_req_wdata;
                wr_count     <= wr_count + 1;
                last_wr_addr <= mem_req_addr;
                last_wr_data <= mem_req_wdata;
            end else begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_rdata <= pmem[off[7:2]];
                rd_count      <= rd_count + 1;
                last_rd_addr  <= mem_req_addr;
            end
        end
    end

    int n_checks = 0;
    int n_fail   = 0;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic preload(input int idx, input logic [31:0] data);
        @(negedge clk);
        pre_en = 1'b1; pre_idx = idx[5:0]; pre_data = data;
        @(negedge clk);
        pre_en = 1'b0;
    endtask

    logic           got_fault, got_refill;
    logic [PA_W-1:0] got_paddr;
    logic [19:0]    got_vpn;
    logic [PPN_W-1:0] got_ppn;

    task automatic wait_done();
        int n = 0;
        while (!done_valid && n < 1000) begin
            @(negedge clk);
            n++;
        end
        if (!done_valid) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual no completion expected completion");
        end
        got_fault  = done_fault;
        got_refill = refill_we;
        got_paddr  = done_paddr;
        got_vpn    = refill_vpn;
        got_ppn    = refill_ppn;
        @(negedge clk);
    endtask

    task automatic run_miss(input logic [31:0] va, input logic wr,
                            input logic [CL_W-1:0] src, input logic [CL_W-1:0] dst);
        @(negedge clk);
        miss_valid = 1'b1; miss_vaddr = va; miss_write = wr;
        miss_src_cluster = src; miss_dst_cluster = dst;
        @(negedge clk);
        miss_valid = 1'b0;
        wait_done();
    endtask

    task automatic t_reset();
        check("R1 busy", busy, 0);
        check("R1 req", mem_req_valid, 0);
        check("R1 done", done_valid, 0);
        check("R1 refill", refill_we, 0);
    endtask

    // read, same cluster, clean entry
    task automatic t_read_local();
        logic [31:0] pte = {28'h0ABCDEF, 4'b0001};
        int w0;
        preload(3, pte);
        w0 = wr_count;
        run_miss(32'h0000_3A5C, 1'b0, 4'd2, 4'd2);
        check("R2 read addr", last_rd_addr, BASE + 40'd12);
        check("R5 paddr", got_paddr, {28'h0ABCDEF, 12'hA5C});
        check("R5 refill", got_refill, 1);
        check("R5 vpn", got_vpn, 20'h00003);
        check("R5 ppn", got_ppn, 28'h0ABCDEF);
        check("R10 one write", wr_count - w0, 1);
        check("R10 wr addr", last_wr_addr, BASE + 40'd12);
        check("R7 local set", last_wr_data, {28'h0ABCDEF, 4'b0101});
        check("R11 dirty clear", last_wr_data[1], 0);
    endtask

    // write, cross cluster: dirty and remote bits in one writeback
    task automatic t_write_remote();
        logic [31:0] pte = {28'h0123456, 4'b0001};
        preload(5, pte);
        run_miss(32'h0000_5FFF, 1'b1, 4'd1, 4'd4);
        check("R6 R8 wb data", last_wr_data, {28'h0123456, 4'b1011});
        check("R5 paddr", got_paddr, {28'h0123456, 12'hFFF});
        check("R6 fault", got_fault, 0);
    endtask

    task automatic t_no_change();
        int w0 = wr_count;
        run_miss(32'h0000_3000, 1'b0, 4'd7, 4'd7);
        check("R9 no write", wr_count - w0, 0);
        check("R9 refill", got_refill, 1);
        check("R9 paddr", got_paddr, {28'h0ABCDEF, 12'h000});
    endtask

    task automatic t_fault();
        int w0 = wr_count;
        preload(7, 32'hFFFF_FFF0);
        run_miss(32'h0000_7123, 1'b1, 4'd0, 4'd3);
        check("R4 fault", got_fault, 1);
        check("R4 no refill", got_refill, 0);
        check("R4 no write", wr_count - w0, 0);
    endtask

    task automatic t_busy();
        int r0 = rd_count;
        int dones = 0;
        @(negedge clk);
        miss_valid = 1'b1; miss_vaddr = 32'h0000_3004; miss_write = 1'b0;
        miss_src_cluster = 4'd2; miss_dst_cluster = 4'd2;
        @(negedge clk);
        check("R3 busy", busy, 1);
        miss_vaddr = 32'h0000_5004; miss_write = 1'b1;
        repeat (2) @(negedge clk);
        miss_valid = 1'b0;
        wait_done();
        check("R3 first vpn", got_vpn, 20'h00003);
        check("R3 one read", rd_count - r0, 1);
        for (int i = 0; i < 6; i++) begin
            if (done_valid) dones++;
            @(negedge clk);
        end
        check("R3 no second done", dones, 0);
        check("R3 idle", busy, 0);
        check("R3 reads", rd_count - r0, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_read_local();
        t_write_remote();
        t_no_change();
        t_fault();
        t_busy();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule